// File: doc/BRIEF.md
# Dual-Port GPIO with Pull-Up Line Resolution

This block provides two 16-pin general-purpose I/O ports behind a small register bus. Each port has a 32-bit control word and a 16-bit output data register. Every pin is resolved from three sources: the CPU output driver, a driver owned by an external peripheral, and a pull-up. Software reading a port's data address sees the resolved pin levels, not the value it last wrote.

Up to four watchers can be attached. Each watcher has an enable bit and a trigger mask for each port. Any register write may change a port's resolved lines. When that happens, the block compares the lines from before the write with the lines after it. It then pulses the notify bit of every enabled watcher whose mask on that port overlaps the changed bits. The pulse lasts one cycle and arrives together with the updated lines of both ports. Changes made only by the peripheral inputs raise no notification.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset, both control words and both data registers are zero, every address reads 0, both line outputs are 0 and no notify bit is set.
- R2: In a port's control word, bit 2n set makes the CPU drive pin n with bit n of that port's data register.
- R3: In a port's control word, bit 2n+1 set pulls pin n to 1 whenever neither the CPU nor the peripheral drives it. An undriven pin without a pull-up reads 0.
- R4: A pin the peripheral drives (its per_dir bit set) carries per_out. When the CPU and the peripheral both drive a pin, the line is the OR of their two values.
- R5: Address map: 0 = port A control, 1 = port A data, 2 = port B control, 3 = port B data. Control reads return the stored 32-bit word. Data reads return the resolved lines in bits 15:0 and zeros in bits 31:16.
- R6: A control write takes effect only with bus_wide=1. A data write takes effect only with bus_wide=0 and uses bits 15:0. A write of the wrong width is ignored.
- R7: A write that leaves the written port's resolved lines unchanged produces no notification.
- R8: One cycle after a write, notify[w] is 1 exactly when watch_en[w] is set and the watcher's mask for the written port ANDs to a nonzero value with (old lines XOR new lines). The lines outputs already show the new values in that cycle.
- R9: Changes on the peripheral inputs alone, or cycles without a write, never raise notify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| per_dir_a | input | 16 | Peripheral drive enables, port A |
| per_out_a | input | 16 | Peripheral drive values, port A |
| per_dir_b | input | 16 | Peripheral drive enables, port B |
| per_out_b | input | 16 | Peripheral drive values, port B |
| watch_en | input | 4 | Watcher enables |
| trig_a | input | 64 | Port A trigger masks, 16 bits per watcher, watcher 0 lowest |
| trig_b | input | 64 | Port B trigger masks, 16 bits per watcher, watcher 0 lowest |
| lines_a | output | 16 | Resolved lines, port A |
| lines_b | output | 16 | Resolved lines, port B |
| notify | output | 4 | One-cycle change pulse per watcher |

## Verification
The assertions check four things on every cycle. A notify pulse only ever follows a write cycle and only for a watcher that was enabled. Idle cycles leave notify low. A write of the wrong width leaves the targeted register unchanged. The bench scenarios are needed for the rest: the resolution of CPU, peripheral and pull-up drivers into line values, the readback of resolved lines, and the choice of which watchers fire. For each write, the bench computes the expected values from a reference model of the pins and queues them, so the mask overlap rules are checked cycle by cycle.

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int PINS     = 16,
  parameter int WATCHERS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_wide,
  input  logic [1:0]                 bus_addr,
  input  logic [2*PINS-1:0]          bus_wdata,
  output logic [2*PINS-1:0]          bus_rdata,
  input  logic [PINS-1:0]            per_dir_a,
  input  logic [PINS-1:0]            per_out_a,
  input  logic [PINS-1:0]            per_dir_b,
  input  logic [PINS-1:0]            per_out_b,
  input  logic [WATCHERS-1:0]        watch_en,
  input  logic [WATCHERS*PINS-1:0]   trig_a,
  input  logic [WATCHERS*PINS-1:0]   trig_b,
  output logic [PINS-1:0]            lines_a,
  output logic [PINS-1:0]            lines_b,
  output logic [WATCHERS-1:0]        notify
);
  localparam int CW = 2 * PINS;

  logic [CW-1:0]   ctrl_a, ctrl_b, nxt_ctrl_a, nxt_ctrl_b;
  logic [PINS-1:0] data_a, data_b, nxt_data_a, nxt_data_b;
  logic [PINS-1:0] new_a, new_b, chg_a, chg_b;
  logic [WATCHERS-1:0] hit;

  function automatic logic [PINS-1:0] resolve(input logic [CW-1:0] c, input logic [PINS-1:0] d,
                                               input logic [PINS-1:0] pd, input logic [PINS-1:0] po);
    logic [PINS-1:0] r;
    for (int n = 0; n < PINS; n++)
      r[n] = (c[2*n] & d[n]) | (pd[n] & po[n]) | (~(c[2*n] | pd[n]) & c[2*n+1]);
    return r;
  endfunction

  wire wr_ca = bus_wr &  bus_wide & (bus_addr == 2'd0);
  wire wr_da = bus_wr & ~bus_wide & (bus_addr == 2'd1);
  wire wr_cb = bus_wr &  bus_wide & (bus_addr == 2'd2);
  wire wr_db = bus_wr & ~bus_wide & (bus_addr == 2'd3);

  assign nxt_ctrl_a = wr_ca ? bus_wdata : ctrl_a;
  assign nxt_ctrl_b = wr_cb ? bus_wdata : ctrl_b;
  assign nxt_data_a = wr_da ? bus_wdata[PINS-1:0] : data_a;
  assign nxt_data_b = wr_db ? bus_wdata[PINS-1:0] : data_b;

  assign lines_a = resolve(ctrl_a, data_a, per_dir_a, per_out_a);
  assign lines_b = resolve(ctrl_b, data_b, per_dir_b, per_out_b);
  assign new_a   = resolve(nxt_ctrl_a, nxt_data_a, per_dir_a, per_out_a);
  assign new_b   = resolve(nxt_ctrl_b, nxt_data_b, per_dir_b, per_out_b);
  assign chg_a   = (wr_ca | wr_da) ? (new_a ^ lines_a) : '0;
  assign chg_b   = (wr_cb | wr_db) ? (new_b ^ lines_b) : '0;

  for (genvar w = 0; w < WATCHERS; w++) begin : g_watch
    assign hit[w] = watch_en[w] & ((|(trig_a[w*PINS +: PINS] & chg_a)) |
                                   (|(trig_b[w*PINS +: PINS] & chg_b)));
    // R8
    notify_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      notify[w] |-> $past(watch_en[w]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_a <= '0;
      ctrl_b <= '0;
      data_a <= '0;
      data_b <= '0;
      notify <= '0;
    end else begin
      ctrl_a <= nxt_ctrl_a;
      ctrl_b <= nxt_ctrl_b;
      data_a <= nxt_data_a;
      data_b <= nxt_data_b;
      notify <= hit;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctrl_a;
      2'd1:    bus_rdata = {{PINS{1'b0}}, lines_a};
      2'd2:    bus_rdata = ctrl_b;
      default: bus_rdata = {{PINS{1'b0}}, lines_b};
    endcase
  end

  // R8
  notify_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|notify) |-> $past(bus_wr));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (notify == '0));

  // R6
  ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wide && !bus_addr[0]) |=> ($stable(ctrl_a) && $stable(ctrl_b)));

  // R6
  data_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wide && bus_addr[0]) |=> ($stable(data_a) && $stable(data_b)));
endmodule

// File: tb/gpio_dual_port_test.sv
module gpio_dual_port_test;
  localparam int P = 16;
  localparam int W = 4;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_wide = 0;
  logic [1:0] bus_addr = 0;
  logic [2*P-1:0] bus_wdata = 0, bus_rdata;
  logic [P-1:0] per_dir_a = 0, per_out_a = 0, per_dir_b = 0, per_out_b = 0;
  logic [W-1:0] watch_en = 0;
  logic [W*P-1:0] trig_a = 0, trig_b = 0;
  logic [P-1:0] lines_a, lines_b;
  logic [W-1:0] notify;

  gpio_dual_port #(.PINS(P), .WATCHERS(W)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic [W-1:0] n; logic [P-1:0] a; logic [P-1:0] b; string tag; } exp_t;
  exp_t q[$];

  logic [2*P-1:0] m_ca = 0, m_cb = 0;
  logic [P-1:0] m_da = 0, m_db = 0;

  function automatic logic [P-1:0] res(logic [2*P-1:0] c, logic [P-1:0] d, logic [P-1:0] pd, logic [P-1:0] po);
    logic [P-1:0] r;
    for (int n = 0; n < P; n++) begin
      if (c[2*n] || pd[n]) r[n] = (c[2*n] & d[n]) | (pd[n] & po[n]);
      else r[n] = c[2*n+1];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic wide, string tag);
    logic [P-1:0] oa, ob, na, nb, ca, cb;
    exp_t e;
    @(negedge clk);
    oa = res(m_ca, m_da, per_dir_a, per_out_a);
    ob = res(m_cb, m_db, per_dir_b, per_out_b);
    if (wide && a == 0) m_ca = d;
    if (!wide && a == 1) m_da = d[P-1:0];
    if (wide && a == 2) m_cb = d;
    if (!wide && a == 3) m_db = d[P-1:0];
    na = res(m_ca, m_da, per_dir_a, per_out_a);
    nb = res(m_cb, m_db, per_dir_b, per_out_b);
    ca = na ^ oa;
    cb = nb ^ ob;
    e.due = cyc + 1; e.a = na; e.b = nb; e.tag = tag;
    for (int w = 0; w < W; w++)
      e.n[w] = watch_en[w] && ((trig_a[w*P +: P] & ca) != 0 || (trig_b[w*P +: P] & cb) != 0);
    q.push_back(e);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_wide = wide;
    @(negedge clk);
    bus_wr = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " notify"}, {28'd0, notify}, {28'd0, e.n});
      check({e.tag, " lines_a"}, {16'd0, lines_a}, {16'd0, e.a});
      check({e.tag, " lines_b"}, {16'd0, lines_b}, {16'd0, e.b});
    end
  end

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    watch_en = 4'b0111;
    trig_a[0*P +: P] = 16'hFFFF;
    trig_a[1*P +: P] = 16'h0001;
    trig_b[2*P +: P] = 16'h00F0;
    trig_a[3*P +: P] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(a[1:0], 32'h0, "R1 read after reset");
    check("R1 lines_a", {16'd0, lines_a}, 0);
    check("R1 notify", {28'd0, notify}, 0);
    // R7 data write with no driver enabled
    wr(2'd1, 32'h00FF, 0, "R7 undriven data write");
    // R2 R8 enable CPU drivers on port A
    wr(2'd0, 32'h5555_5555, 1, "R2 R8 ctrl A drive");
    // R5 readback
    rd(2'd1, 32'h0000_00FF, "R5 data A read");
    rd(2'd0, 32'h5555_5555, "R5 ctrl A read");
    // R6 wrong-width writes ignored
    wr(2'd0, 32'h0, 0, "R6 narrow ctrl write");
    rd(2'd0, 32'h5555_5555, "R6 ctrl A kept");
    wr(2'd1, 32'h1234, 1, "R6 wide data write");
    // R3 pull-ups on port B
    wr(2'd2, 32'hAAAA_AAAA, 1, "R3 pull-ups B");
    // R9 peripheral-only change
    @(negedge clk);
    per_dir_b = 16'h00FF; per_out_b = 16'h000F;
    repeat (2) @(negedge clk);
    check("R9 notify quiet", {28'd0, notify}, 0);
    check("R4 R9 lines_b periph", {16'd0, lines_b}, 32'hFF0F);
    // R8 change outside watcher mask
    wr(2'd2, 32'h0000_0001, 1, "R8 mask miss B");
    rd(2'd3, 32'h0000_000F, "R5 data B read");
    // R7 data on undriven pin
    wr(2'd3, 32'h0100, 0, "R7 undriven pin B");
    // R4 OR of CPU and peripheral
    @(negedge clk);
    per_dir_a = 16'h0F00; per_out_a = 16'h0F00;
    @(negedge clk);
    check("R4 lines_a OR", {16'd0, lines_a}, 32'h0FFF);
    wr(2'd1, 32'h0000, 0, "R8 data A clear");
    wr(2'd1, 32'h0001, 0, "R8 pin0 only");
    repeat (3) @(negedge clk);
    check("R8 queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule